// File: doc/BRIEF.md
# Stepper Power-Stage Fault Latch with Chopper Blanking

This block guards the phase drivers of a two-phase stepper power stage. It watches two raw fault flags: a digital overcurrent comparator output and an overheat flag. Each passes through a two-flop synchronizer. Once a fault is accepted, the block latches it, pulls all phase-drive enables low, and turns on the drive-low enable of an open-drain style fault pin. The latch is sticky. Only a reset clears it: the reset input is held low across a clock edge and then returned high.

Overcurrent is not accepted during a blanking window that opens with every chopper period-start strobe. This keeps turn-on ringing from tripping the latch. The window length is a parameter counted in system clock cycles. For example, 275 cycles at 50 MHz gives a 5.5 µs window inside a 20 µs chopper period. Overheat is never blanked. A fault that is still present when reset is released latches again as soon as it has passed through the synchronizer.

Top module: `drv_fault_latch`

## Requirements
- R1: A clock edge with `rst_n` low clears both fault latches. After that edge, `gate_off` and `fault_oe` are 0 and `phase_drv` equals `phase_req`.
- R2: If `oc_raw` is 1 at one clock edge and the blanking window is closed two cycles later, the fault latches. `gate_off` reads 1 after the third edge counted from that sample, and not earlier.
- R3: A `period_start` pulse opens a blanking window of `BLANK_CYC` cycles. The window starts with the cycle in which the strobe is high. An overcurrent sample whose synchronized value falls inside the window is ignored, and the window's last cycle still blanks.
- R4: A `period_start` pulse that arrives while a window is open restarts the window at its full length.
- R5: Overheat (`ot_raw`) is accepted with the same three-edge latency as overcurrent, whether or not the blanking window is open.
- R6: A latched fault stays set after both raw inputs return to 0 and while strobes keep arriving, until the next reset.
- R7: While a fault is latched, `gate_off` is 1 and every bit of `phase_drv` is 0. With no fault, `phase_drv` follows `phase_req` bit for bit.
- R8: `fault_oe` (1 = pull the fault pin low) is 1 exactly while a fault is latched. `fault_dout` is always 0.
- R9: If a raw fault input is still 1 when `rst_n` returns high, the fault latches again. It is visible after the third edge with `rst_n` high.
- R10: From reset until the first `period_start`, no blanking window is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the latches |
| period_start | input | 1 | One-cycle strobe at the start of each chopper period |
| oc_raw | input | 1 | Raw overcurrent comparator flag, active high |
| ot_raw | input | 1 | Raw overheat flag, active high |
| phase_req | input | NPHASE | Phase-drive enables requested by the sequencer |
| phase_drv | output | NPHASE | Phase-drive enables passed to the power stage |
| gate_off | output | 1 | 1 while a fault holds all phases off |
| fault_oe | output | 1 | Drive-low enable of the open-drain fault pin |
| fault_dout | output | 1 | Value driven on the fault pin when enabled (0) |

## Verification
The bench builds the block with `BLANK_CYC` = 4 rather than 275, with four phases and two synchronizer stages. The short window means that the first and last blanked cycles, the first open cycle, and a restart partway through a window all fall within a handful of cycles. Each of them is checked at the exact cycle in which the latch can change. At the default 275 cycles, the same edges could be reached only through long idle stretches.

// File: rtl/drv_fault_pkg.sv
// Package: shared types for the fault latch.
// Assumes: exactly two fault causes, overcurrent and overheat.
package drv_fault_pkg;
    localparam int FL_NUM_CAUSES = 2;

    // One bit per fault cause, carried as a bundle through synchronizer and latch.
    typedef struct packed {
        logic oc;
        logic ot;
    } fl_cause_t;
endpackage

// File: rtl/fl_sync.sv
// Module: fl_sync
// A multi-stage synchronizer chain, one chain per bit of a bus.
// Assumes: the bits are unrelated level flags, so per-bit skew is acceptable.
// The chain resets to 0 on the synchronous active-low reset.
module fl_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                // Later flops let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fl_blank_timer.sv
// Module: fl_blank_timer
// Produces the overcurrent blanking window, BLANK_CYC cycles long. The
// window begins with the cycle in which the strobe is high, and a new
// strobe restarts it at full length.
// Assumes: period_start is synchronous to clk and lasts one cycle.
// BLANK_CYC == 0 disables blanking entirely.
module fl_blank_timer #(
    parameter int BLANK_CYC = 275
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_start,
    output logic blank_o
);
    localparam int CNT_W = (BLANK_CYC > 2) ? $clog2(BLANK_CYC) : 1;

    generate
        if (BLANK_CYC == 0) begin : g_none
            assign blank_o = 1'b0;
        end else if (BLANK_CYC == 1) begin : g_strobe_only
            assign blank_o = period_start;
        end else begin : g_count
            logic [CNT_W-1:0] remain_q;

            // Down-counter of the blanked cycles that remain after the strobe cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    remain_q <= '0;
                else if (period_start)
                    remain_q <= CNT_W'(BLANK_CYC - 1);
                else if (remain_q != '0)
                    remain_q <= remain_q - 1'b1;
            end

            assign blank_o = period_start || (remain_q != '0);
        end
    endgenerate
endmodule

// File: rtl/fl_latch.sv
// Module: fl_latch
// Sticky per-cause fault latches. Overcurrent is accepted only while the
// blanking window is closed; overheat is accepted at any time.
// Assumes: inputs are already synchronized to clk. Only reset clears.
module fl_latch
    import drv_fault_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  fl_cause_t cause_i,
    input  logic      blank_i,
    output fl_cause_t latched_o
);
    fl_cause_t lat_q;
    logic      oc_accept;

    // Qualify overcurrent against the blanking window.
    always_comb oc_accept = cause_i.oc && !blank_i;

    // Set-only latches; a reset edge is the only way back to clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q.oc <= lat_q.oc || oc_accept;
            lat_q.ot <= lat_q.ot || cause_i.ot;
        end
    end

    assign latched_o = lat_q;
endmodule

// File: rtl/drv_fault_latch.sv
// Module: drv_fault_latch (top)
// Fault guard for a stepper power stage: synchronizes the raw overcurrent
// and overheat flags, blanks overcurrent at the start of each chopper
// period, latches any accepted fault, masks every phase-drive enable and
// enables the open-drain fault pull-down.
// Assumes: period_start, phase_req and rst_n are synchronous to clk;
// oc_raw and ot_raw may be asynchronous.
module drv_fault_latch
    import drv_fault_pkg::*;
#(
    parameter int NPHASE      = 4,
    parameter int BLANK_CYC   = 275,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_start,
    input  logic              oc_raw,
    input  logic              ot_raw,
    input  logic [NPHASE-1:0] phase_req,
    output logic [NPHASE-1:0] phase_drv,
    output logic              gate_off,
    output logic              fault_oe,
    output logic              fault_dout
);
    fl_cause_t raw_w;
    fl_cause_t sync_w;
    fl_cause_t lat_w;
    logic      blank_w;
    logic      oc_sync;
    logic      ot_sync;
    logic      any_fault;

    // Bundle the raw flags for the synchronizer.
    always_comb begin
        raw_w.oc = oc_raw;
        raw_w.ot = ot_raw;
    end

    fl_sync #(
        .WIDTH  (FL_NUM_CAUSES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_w),
        .q_o   (sync_w)
    );

    assign oc_sync = sync_w.oc;
    assign ot_sync = sync_w.ot;

    fl_blank_timer #(
        .BLANK_CYC (BLANK_CYC)
    ) u_blank (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .blank_o      (blank_w)
    );

    fl_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_i   (sync_w),
        .blank_i   (blank_w),
        .latched_o (lat_w)
    );

    // Any latched cause shuts the stage down.
    always_comb any_fault = lat_w.oc || lat_w.ot;

    genvar p;
    generate
        for (p = 0; p < NPHASE; p++) begin : g_phase
            // Per-phase gate: request passes only while no fault is held.
            assign phase_drv[p] = phase_req[p] && !any_fault;
        end
    endgenerate

    assign gate_off   = any_fault;
    assign fault_oe   = any_fault;
    assign fault_dout = 1'b0;
endmodule

// File: rtl/fl_checker.sv
// Module: fl_checker
// Property checks on drv_fault_latch, attached by the bind below.
// Assumes: clocked on the same clock as the design; reset is synchronous.
module fl_checker #(
    parameter int NPHASE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              blank,
    input logic              oc_q,
    input logic              ot_q,
    input logic              gate_off,
    input logic              fault_oe,
    input logic [NPHASE-1:0] phase_drv
);
    // R1: a reset edge leaves the stage enabled.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> !gate_off);

    // R2: a synchronized overcurrent outside the window latches next cycle.
    p_oc_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_q && !blank) |=> gate_off);

    // R3: inside the window, overcurrent alone never sets the latch.
    p_blank_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !ot_q && !gate_off) |=> !gate_off);

    // R5: overheat sets the latch regardless of blanking.
    p_ot_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ot_q |=> gate_off);

    // R6: once latched, the fault stays until reset.
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off |=> gate_off);

    // R7: a held fault masks every phase.
    p_phases_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off |-> (phase_drv == '0));

    // R8: the pin pull-down follows the shutdown state.
    p_pin_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_off) |-> fault_oe);
endmodule

bind drv_fault_latch fl_checker #(.NPHASE(NPHASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blank     (blank_w),
    .oc_q      (oc_sync),
    .ot_q      (ot_sync),
    .gate_off  (gate_off),
    .fault_oe  (fault_oe),
    .phase_drv (phase_drv)
);

// File: tb/sim_drv_fault_latch.sv
// Bench for drv_fault_latch: a vector table walked cycle by cycle, then
// directed tests for reset, restart, overheat and stickiness.
module sim_drv_fault_latch;
    localparam int NPH   = 4;
    localparam int BLANK = 4;
    localparam int NVEC  = 13;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           period_start = 1'b0;
    logic           oc_raw = 1'b0;
    logic           ot_raw = 1'b0;
    logic [NPH-1:0] phase_req = '0;
    logic [NPH-1:0] phase_drv;
    logic           gate_off;
    logic           fault_oe;
    logic           fault_dout;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    drv_fault_latch #(
        .NPHASE      (NPH),
        .BLANK_CYC   (BLANK),
        .SYNC_STAGES (2)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .oc_raw       (oc_raw),
        .ot_raw       (ot_raw),
        .phase_req    (phase_req),
        .phase_drv    (phase_drv),
        .gate_off     (gate_off),
        .fault_oe     (fault_oe),
        .fault_dout   (fault_dout)
    );

    always #10 clk = ~clk;

    // Row: {rst_n, period_start, oc_raw, ot_raw, phase_req[3:0], expected gate_off}.
    // Each row is applied before one edge; the expected value holds after that edge.
    localparam logic [8:0] VEC [NVEC] = '{
        9'b0_0_0_0_1010_0,  // 0  reset
        9'b1_0_0_0_0101_0,  // 1  idle
        9'b1_1_0_0_0101_0,  // 2  strobe: window rows 2..5
        9'b1_0_1_0_0110_0,  // 3  oc lands in row 5 (blanked)
        9'b1_0_0_0_0110_0,  // 4
        9'b1_0_0_0_0110_0,  // 5  last blanked cycle, rejected
        9'b1_0_0_0_1111_0,  // 6
        9'b1_1_0_0_1111_0,  // 7  strobe: window rows 7..10
        9'b1_0_1_0_1111_0,  // 8  oc lands in row 10 (blanked)
        9'b1_0_1_0_1111_0,  // 9  oc lands in row 11 (open)
        9'b1_0_0_0_1111_0,  // 10
        9'b1_0_0_0_1111_1,  // 11 latched
        9'b1_0_0_0_1001_1   // 12 still masked
    };

    function automatic string vec_tag(int i);
        if (i <= 1)  return "R1";
        if (i <= 6)  return "R3";
        if (i <= 10) return "R3";
        return "R2";
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Apply one cycle of stimulus at the falling edge; return just after the rising edge.
    task automatic step(logic r, logic s, logic oc, logic ot);
        @(negedge clk);
        rst_n        = r;
        period_start = s;
        oc_raw       = oc;
        ot_raw       = ot;
        @(posedge clk);
        #1;
    endtask

    task automatic check_off(string tag, logic exp);
        check(tag, {7'd0, gate_off}, {7'd0, exp});
    endtask

    initial begin
        // Vector table walk.
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            rst_n        = VEC[i][8];
            period_start = VEC[i][7];
            oc_raw       = VEC[i][6];
            ot_raw       = VEC[i][5];
            phase_req    = VEC[i][4:1];
            @(posedge clk);
            #1;
            check(vec_tag(i), {7'd0, gate_off}, {7'd0, VEC[i][0]});
            check("R7", {4'd0, phase_drv}, {4'd0, (VEC[i][0] ? 4'b0000 : VEC[i][4:1])});
            check("R8", {6'd0, fault_oe, fault_dout}, {6'd0, VEC[i][0], 1'b0});
        end

        // R1 and R9: reset clears, and a held overcurrent re-latches after release (R10: no window).
        phase_req = 4'b1100;
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check_off("R1", 1'b0);
        check("R1", {4'd0, phase_drv}, 8'h0C);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check_off("R1", 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        check_off("R9", 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0);
        check_off("R9", 1'b1);
        check_off("R10", 1'b1);

        // R4: a second strobe two cycles in extends the window over the oc sample.
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0);   // s
        step(1'b1, 1'b0, 1'b0, 1'b0);   // s+1
        step(1'b1, 1'b1, 1'b1, 1'b0);   // s+2 restart, oc checked at s+4
        step(1'b1, 1'b0, 1'b0, 1'b0);   // s+3
        step(1'b1, 1'b0, 1'b0, 1'b0);   // s+4
        check_off("R4", 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0, 1'b0);
        check_off("R4", 1'b0);

        // R5: overheat inside a window is accepted with three-edge latency.
        step(1'b1, 1'b1, 1'b0, 1'b1);   // s, ot checked at s+2 (blanked cycle)
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check_off("R5", 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check_off("R5", 1'b1);

        // R6: stays latched with inputs low and strobes arriving.
        for (int k = 0; k < 6; k++) step(1'b1, (k % 2 == 0), 1'b0, 1'b0);
        check_off("R6", 1'b1);
        check("R8", {6'd0, fault_oe, fault_dout}, 8'h02);
        check("R7", {4'd0, phase_drv}, 8'h00);

        // R1: a single reset edge clears, and it stays clear with quiet inputs.
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check_off("R1", 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0, 1'b0);
        check_off("R1", 1'b0);
        check("R7", {4'd0, phase_drv}, 8'h0C);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule